// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral guards a system against software that has stopped making progress. Software programs a timeout in half-second units and then enables the timer. From then on the timer counts down on a slow half-second strobe and cannot be switched off. Only an exact two-word key sequence, written to the service register, restores the full count. If the count runs out, the block asserts one of two resets and records that a timeout caused it. The chosen reset is either the internal chip reset or an active-low reset pin for external parts.

The interface is a 16-bit register port with a combinational read. It has five registers at even byte offsets: control (0x0), service (0x2), cause (0x4), early warning (0x6) and power-down (0x8). An early-warning interrupt can be raised a programmable number of half-seconds before expiry. Software can also force either reset directly through two active-low control bits. A pause option stops the count during low-power mode, and it can be set only once per reset.

There are two reset inputs. `rst_n` is the system reset, which the internal reset output would normally drive. It clears the counter, the control state and the interrupt state. `por_n` is the power-on reset, and it also clears the cause register. The cause therefore survives the reset that the watchdog itself caused.

Top module: `kwdog`

## Requirements
- R1: After reset, control reads 0x0030, cause reads 0x0000, early warning reads 0x0000 and power-down reads 0x0001. Both reset outputs are inactive (`rst_int_o`=0, `rst_ext_n_o`=1) and `irq_o` is 0.
- R2: Setting control bit 2 with timeout field N in bits 15:8 loads a count of N+1. Each `tick` pulse while running lowers the count by one, and the pulse that takes the count from 1 to 0 is the timeout.
- R3: Once control bit 2 is set, writing 0 to it leaves it set and the count keeps running.
- R4: Writing 0x5555 and then 0xAAAA to the service register (0x2) reloads the count to N+1. Writes to other registers between the two words do not break the sequence.
- R5: Any service write other than the expected next word returns the checker to waiting for 0x5555, and that write does not reload. This includes a second 0x5555, and 0xAAAA written without a preceding 0x5555.
- R6: A new timeout field written while running does not change the current count; it is used at the next reload.
- R7: On timeout, control bit 3 selects the action. When bit 3 is 0, `rst_int_o` goes to 1. When bit 3 is 1, only `rst_ext_n_o` goes to 0. The asserted output holds until system reset.
- R8: Writing 0 to control bit 4 asserts `rst_int_o` and sets cause bit 0. While control bit 5 holds 0, `rst_ext_n_o` is 0.
- R9: A timeout sets cause bit 1 and clears cause bit 0. The cause register keeps its value through `rst_n` and is cleared only by `por_n`.
- R10: In the early-warning register, bits 7:0 hold the lead L and bit 15 enables the warning. If bit 15 is set, a tick that brings the count down to L sets status bit 14. `irq_o` is bit 15 AND bit 14, and writing 1 to bit 14 clears it.
- R11: The first control write after reset fixes pause bit 0, and later writes cannot change it. While bit 0 is 1 and `low_power` is 1, ticks do not change the count.
- R12: Power-down register bit 0 resets to 1, and a write of 0 clears it until reset. `pd_en_o` follows this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause register |
| rst_n | input | 1 | System reset, active low; clears all but the cause register |
| tick | input | 1 | One-cycle half-second count strobe |
| low_power | input | 1 | System is in low-power mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | Early-warning interrupt, active high |
| rst_int_o | output | 1 | Internal chip reset request, active high |
| rst_ext_n_o | output | 1 | External reset pin, active low |
| pd_en_o | output | 1 | Power-down counter enable |

## Verification
A register write takes effect at the clock edge that samples it. The bench can see the new value on `rdata` from the next falling edge, because the read path has no register. A tick pulse updates the count, the early-warning flag and both reset outputs at that same edge. A software reset request reaches `rst_int_o` one edge after its write, and `rst_ext_n_o` follows control bit 5 with the same delay. The bench drives every stimulus on a falling edge and holds it for one full cycle. It samples 1 ns after the next falling edge, so each result is read half a cycle after the edge that produced it. Because the count has no read port, it is observed only through the timing of expiry and of the early-warning flag.

// File: rtl/kwdog.sv
module kwdog #(
  parameter int          TW       = 8,
  parameter logic [15:0] KEY_ARM  = 16'h5555,
  parameter logic [15:0] KEY_FIRE = 16'hAAAA
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        low_power,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq_o,
  output logic        rst_int_o,
  output logic        rst_ext_n_o,
  output logic        pd_en_o
);
  localparam int CW = TW + 1;

  logic [TW-1:0] tmo, lead;
  logic [CW-1:0] cnt, cnt_nx, load_val, field_val;
  logic pause, pause_lk, act_ext, srs_n, wda_n, en;
  logic armed, ie, is_, pd_en, trip_int, trip_ext;
  logic tout_st, sw_st;
  logic wr_ctl, wr_svc, wr_icr, wr_msc;
  logic fire, en_rise, run, step, expire, pre_hit, sw_req;
  logic [15:0] ctl_rd, cause_rd, icr_rd;

  assign wr_ctl = wr_en && addr == 4'h0;
  assign wr_svc = wr_en && addr == 4'h2;
  assign wr_icr = wr_en && addr == 4'h6;
  assign wr_msc = wr_en && addr == 4'h8;

  assign field_val = CW'(wdata[8 +: TW]) + CW'(1);
  assign load_val  = CW'(tmo) + CW'(1);
  assign fire      = wr_svc && armed && wdata == KEY_FIRE;
  assign en_rise   = wr_ctl && !en && wdata[2];
  assign run       = en && !(pause && low_power);
  assign step      = run && tick && cnt != '0;
  assign cnt_nx    = cnt - CW'(1);
  assign expire    = step && cnt == CW'(1);
  assign pre_hit   = step && ie && cnt_nx == CW'(lead);
  assign sw_req    = wr_ctl && !wdata[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo <= '0; pause <= 1'b0; pause_lk <= 1'b0; act_ext <= 1'b0;
      srs_n <= 1'b1; wda_n <= 1'b1; en <= 1'b0;
    end else if (wr_ctl) begin
      tmo      <= wdata[8 +: TW];
      act_ext  <= wdata[3];
      srs_n    <= wdata[4];
      wda_n    <= wdata[5];
      en       <= en | wdata[2];
      pause_lk <= 1'b1;
      if (!pause_lk) pause <= wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (en_rise)      cnt <= field_val;
    else if (fire && en)   cnt <= load_val;
    else if (step)         cnt <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      armed <= 1'b0;
    else if (wr_svc) armed <= !armed && wdata == KEY_ARM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_int <= 1'b0; trip_ext <= 1'b0;
    end else begin
      trip_int <= trip_int | (expire && !act_ext) | sw_req;
      trip_ext <= trip_ext | (expire && act_ext);
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      tout_st <= 1'b0; sw_st <= 1'b0;
    end else if (rst_n) begin
      if (expire)      begin tout_st <= 1'b1; sw_st <= 1'b0; end
      else if (sw_req) begin tout_st <= 1'b0; sw_st <= 1'b1; end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie <= 1'b0; is_ <= 1'b0; lead <= '0; pd_en <= 1'b1;
    end else begin
      if (wr_icr) begin
        ie   <= wdata[15];
        lead <= wdata[TW-1:0];
      end
      is_   <= (is_ & ~(wr_icr & wdata[14])) | pre_hit;
      if (wr_msc) pd_en <= pd_en & wdata[0];
    end

  assign ctl_rd   = (16'(tmo) << 8) | {10'b0, wda_n, srs_n, act_ext, en, 1'b0, pause};
  assign cause_rd = {14'b0, tout_st, sw_st};
  assign icr_rd   = {ie, is_, 6'b0, 8'(lead)};

  always_comb
    case (addr)
      4'h0:    rdata = ctl_rd;
      4'h4:    rdata = cause_rd;
      4'h6:    rdata = icr_rd;
      4'h8:    rdata = {15'b0, pd_en};
      default: rdata = '0;
    endcase

  assign irq_o       = ie & is_;
  assign rst_int_o   = trip_int;
  assign rst_ext_n_o = wda_n & ~trip_ext;
  assign pd_en_o     = pd_en;
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(parameter int CW = 9) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          low_power,
  input logic          en,
  input logic          pause,
  input logic          fire,
  input logic          en_rise,
  input logic          ie,
  input logic          irq_o,
  input logic          rst_int_o,
  input logic [CW-1:0] cnt
);
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r4_no_rise_without_key: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire || en_rise) |=> cnt <= $past(cnt));

  a_r2_one_step_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !(pause && low_power) && cnt > CW'(1) && !fire)
      |=> cnt == $past(cnt) - CW'(1));

  a_r11_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pause && low_power && !fire) |=> cnt == $past(cnt));

  a_r7_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rst_int_o |=> rst_int_o);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie);
endmodule

bind kwdog kwdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .low_power(low_power),
  .en(en), .pause(pause), .fire(fire), .en_rise(en_rise),
  .ie(ie), .irq_o(irq_o), .rst_int_o(rst_int_o), .cnt(cnt)
);

// File: tb/kwdog_test.sv
module kwdog_test;
  localparam time PERIOD = 10ns;
  localparam logic [2:0] OW = 0, OR = 1, OT = 2, OO = 3, OL = 4, OX = 5, OP = 6;

  logic clk = 0, por_n = 0, rst_n = 0, tick = 0, low_power = 0, wr_en = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq_o, rst_int_o, rst_ext_n_o, pd_en_o;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  kwdog uut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
    .low_power(low_power), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .rst_int_o(rst_int_o),
    .rst_ext_n_o(rst_ext_n_o), .pd_en_o(pd_en_o));

  function automatic logic [42:0] mk(input logic [3:0] r, input logic [2:0] o,
      input logic [3:0] a, input logic [15:0] d, input logic [15:0] e);
    return {r, o, a, d, e};
  endfunction

  // outputs checked as {pd_en_o, rst_int_o, rst_ext_n_o, irq_o}
  localparam logic [42:0] VEC [63] = '{
    mk(1, OR, 0, 0, 16'h0030),       // R1 control reset value
    mk(1, OR, 4, 0, 16'h0000),       // R1 cause reset value
    mk(12, OR, 8, 0, 16'h0001),      // R12 power-down reset value
    mk(1, OO, 0, 0, 16'hA),          // R1 outputs idle
    mk(12, OW, 8, 0, 0),             // R12 disable power-down
    mk(12, OR, 8, 0, 16'h0000),      // R12
    mk(12, OO, 0, 0, 16'h2),         // R12 pd_en_o low
    mk(11, OW, 0, 16'h0331, 0),      // R11 first write sets pause
    mk(11, OR, 0, 0, 16'h0331),      // R11
    mk(11, OW, 0, 16'h0330, 0),      // R11 second write cannot clear pause
    mk(11, OR, 0, 0, 16'h0331),      // R11
    mk(2, OW, 0, 16'h0335, 0),       // R2 enable, N=3, count 4
    mk(3, OW, 0, 16'h0331, 0),       // R3 try to disable
    mk(3, OR, 0, 0, 16'h0335),       // R3 still enabled
    mk(11, OL, 0, 1, 0),             // R11 low power on
    mk(11, OT, 0, 10, 0),            // R11 ticks ignored
    mk(11, OL, 0, 0, 0),             // R11 low power off
    mk(11, OO, 0, 0, 16'h2),         // R11 no expiry
    mk(4, OT, 0, 3, 0),              // R4 count 1
    mk(4, OO, 0, 0, 16'h2),          // R4
    mk(4, OW, 2, 16'h5555, 0),       // R4 first key
    mk(4, OW, 6, 16'h0000, 0),       // R4 other register in between
    mk(4, OW, 2, 16'hAAAA, 0),       // R4 second key, count 4
    mk(4, OT, 0, 3, 0),              // R4 count 1
    mk(4, OO, 0, 0, 16'h2),          // R4 reload took effect
    mk(5, OW, 2, 16'h5555, 0),       // R5
    mk(5, OW, 2, 16'h1234, 0),       // R5 wrong word
    mk(5, OW, 2, 16'hAAAA, 0),       // R5 must not reload
    mk(2, OT, 0, 1, 0),              // R2 fourth tick expires
    mk(7, OO, 0, 0, 16'h6),          // R7 internal reset
    mk(9, OR, 4, 0, 16'h0002),       // R9 timeout cause
    mk(9, OX, 0, 0, 0),              // R9 system reset
    mk(9, OR, 4, 0, 16'h0002),       // R9 cause kept
    mk(1, OR, 0, 0, 16'h0030),       // R1 control cleared
    mk(1, OO, 0, 0, 16'hA),          // R1 outputs released
    mk(10, OW, 6, 16'h8002, 0),      // R10 warning on, lead 2
    mk(10, OR, 6, 0, 16'h8002),      // R10
    mk(7, OW, 0, 16'h053C, 0),       // R7 external action, N=5, count 6
    mk(6, OW, 0, 16'h013C, 0),       // R6 new field N=1 while running
    mk(6, OT, 0, 3, 0),              // R6 count 3
    mk(6, OO, 0, 0, 16'hA),          // R6 old count kept
    mk(10, OT, 0, 1, 0),             // R10 count 2 equals lead
    mk(10, OO, 0, 0, 16'hB),         // R10 irq
    mk(10, OR, 6, 0, 16'hC002),      // R10 status set
    mk(10, OW, 6, 16'hC002, 0),      // R10 write 1 clears
    mk(10, OR, 6, 0, 16'h8002),      // R10 status cleared
    mk(6, OW, 2, 16'h5555, 0),       // R6
    mk(6, OW, 2, 16'hAAAA, 0),       // R6 reload uses N=1, count 2
    mk(6, OT, 0, 1, 0),              // R6 count 1
    mk(7, OT, 0, 1, 0),              // R7 expire, external
    mk(7, OO, 0, 0, 16'h8),          // R7 only external pin
    mk(9, OR, 4, 0, 16'h0002),       // R9
    mk(9, OP, 0, 0, 0),              // R9 power-on reset
    mk(9, OR, 4, 0, 16'h0000),       // R9 cause cleared
    mk(1, OR, 6, 0, 16'h0000),       // R1 warning register cleared
    mk(8, OW, 0, 16'h0020, 0),       // R8 software reset request
    mk(8, OO, 0, 0, 16'hE),          // R8
    mk(8, OR, 4, 0, 16'h0001),       // R8 software cause
    mk(8, OX, 0, 0, 0),              // R8
    mk(8, OW, 0, 16'h0010, 0),       // R8 external pin forced low
    mk(8, OO, 0, 0, 16'h8),          // R8
    mk(8, OW, 0, 16'h0030, 0),       // R8 release
    mk(8, OO, 0, 0, 16'hA)           // R8
  };

  task automatic check(input int r, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1; @(negedge clk); tick = 0; end
  endtask

  task automatic outs(input int r, input logic [3:0] e);
    @(negedge clk); #1;
    check(r, {12'b0, pd_en_o, rst_int_o, rst_ext_n_o, irq_o}, {12'b0, e});
  endtask

  task automatic apply(input logic [42:0] v);
    logic [3:0] r; logic [2:0] o; logic [3:0] a; logic [15:0] d, e;
    {r, o, a, d, e} = v;
    case (o)
      OW: wr(a, d);
      OR: begin @(negedge clk); addr = a; #1; check(r, rdata, e); end
      OT: ticks(d);
      OO: outs(r, e[3:0]);
      OL: begin @(negedge clk); low_power = d[0]; end
      OX: begin @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; end
      default: begin @(negedge clk); por_n = 0; rst_n = 0;
                     @(negedge clk); por_n = 1; rst_n = 1; end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    for (int i = 0; i < 63; i++) apply(VEC[i]);
    // R5 corner: lone second word and a repeated first word
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    wr(0, 16'h0134);
    ticks(1);
    wr(2, 16'hAAAA);
    wr(2, 16'h5555);
    wr(2, 16'h5555);
    wr(2, 16'hAAAA);
    outs(5, 4'hA);
    ticks(1);
    outs(5, 4'hE);  // R5 no reload happened, count expired
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule